// File: doc/BRIEF.md
# Receive Frame Buffer Writer

This block takes an incoming Ethernet frame, presented as a byte stream with valid and last flags, and stores it in one page of packet memory obtained from a page allocator. Each stored frame starts with a four-byte header. The header holds a 16-bit status word and the 16-bit stored size, both least significant byte first. The frame data follows the header. After the data come an optional CRC-32 and a two-byte control word that holds the odd trailing byte, if there is one. Frames shorter than the minimum length are padded with zeros. When the frame is complete, the page number is pushed onto the receive queue and a receive interrupt pulse is raised.

The header can only be known once the frame has ended. The data is therefore written at offset 4 onward while the bytes arrive. After the last byte, the block writes the padding, the CRC and the control word, and then goes back to write the header. Page memory is written through a byte-wide port, one byte per cycle. The stream is held off with `rx_ready_o` while padding and trailer bytes are being written. A frame is dropped in three cases: reception is disabled, no page is free, or the stored size would not fit in one page. In the last case the page is handed back to the allocator.

Top module: `rx_frame_writer`

## Requirements
- R1: A frame is taken only when, at its first byte, control bit 8 (enable) is 1 and control bit 15 (soft reset) is 0. Otherwise every byte is consumed with no allocation request, no memory write and no queue push.
- R2: If `alloc_gnt_i` is low when the first byte of an enabled frame arrives, the whole frame is consumed with no memory write and no queue push.
- R3: Frame byte k is written to offset 4+k of the granted page, in arrival order, one byte per cycle. `rx_ready_o` is low while padding, trailer or header bytes are being written.
- R4: A frame shorter than 64 bytes is extended with zero bytes at offsets 4+L to 67. The padding is included in the CRC.
- R5: When control bit 9 (strip) is 0, the CRC-32 of the padded frame is stored least significant byte first at offset 4+E. E is the padded length rounded down to even. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and is complemented at the end. When bit 9 is 1, no CRC is stored.
- R6: For an odd padded length, the last byte is not stored in the data area. It is the low byte of the control word that follows the CRC (or follows the data when there is no CRC), and the control word's high byte is 0x20. Status bit 12 is set. For an even length, the control word is 0x0000.
- R7: Status bit 11 is set when the frame length exceeds 1518 bytes. All other status bits are 0.
- R8: Offsets 0 and 1 hold the status word and offsets 2 and 3 hold the stored size E+6 (+4 when a CRC is kept), both least significant byte first. These four bytes are written after all other bytes of the frame.
- R9: If the stored size exceeds 2048 bytes, the frame is dropped. `release_o` pulses once with the page on `release_page_o`, and there is no queue push.
- R10: A stored frame ends with a one-cycle `rxq_push_o`, carrying the page on `rxq_page_o`, together with a one-cycle `rx_irq_o`.
- R11: After reset the block is idle: `rx_ready_o` is high, and no write, request, push, release or interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_ctrl_i | input | 16 | Receive control word (bit 15 soft reset, bit 9 strip CRC, bit 8 enable) |
| rx_data_i | input | 8 | Frame byte |
| rx_valid_i | input | 1 | Frame byte valid |
| rx_last_i | input | 1 | Last byte of frame |
| rx_ready_o | output | 1 | Block accepts a byte |
| alloc_req_o | output | 1 | Page request at frame start |
| alloc_gnt_i | input | 1 | Page available this cycle |
| alloc_page_i | input | PW | Granted page number |
| wr_en_o | output | 1 | Page memory byte write |
| wr_page_o | output | PW | Page being written |
| wr_addr_o | output | AW | Byte offset within page |
| wr_data_o | output | 8 | Byte written |
| rxq_push_o | output | 1 | Push page onto receive queue |
| rxq_page_o | output | PW | Page pushed |
| release_o | output | 1 | Return page (oversize frame) |
| release_page_o | output | PW | Page returned |
| rx_irq_o | output | 1 | Receive interrupt pulse |

## Verification
The assertions check the following on every cycle:
- While data bytes stream in, write offsets advance by one and the page does not change.
- Nothing is written or requested while a refused frame drains.
- The stored size presented in the header is even and at least the padded minimum.
- A queue push always directly follows the write of the last header byte.
- The CRC register reseeds to all ones after a clear.

Only the bench's scenarios can show that the byte contents are right. This covers the padding, the CRC value and its position, the placement of the held odd byte, the status bits and the stored size. It also covers the size limit that makes a frame one byte longer go from stored to released.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_DATA, S_DROP, S_PAD, S_EVAL, S_CRC, S_CTL, S_HDR, S_FIN
  } rxw_state_e;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  // one byte through the reflected CRC-32, LSB first
  function automatic logic [31:0] crc_byte(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rxw_ctrl_decode.sv
module rxw_ctrl_decode #(
  parameter int unsigned SRST_BIT  = 15,
  parameter int unsigned STRIP_BIT = 9,
  parameter int unsigned EN_BIT    = 8
) (
  input  logic [15:0] ctrl_i,
  output logic        accept_o,
  output logic        keep_crc_o
);
  logic [15:0] unused_bits;

  assign accept_o    = ctrl_i[EN_BIT] & ~ctrl_i[SRST_BIT];
  assign keep_crc_o  = ~ctrl_i[STRIP_BIT];
  assign unused_bits = ctrl_i;
endmodule

// File: rtl/rxw_crc32.sv
module rxw_crc32 (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o
);
  import rxw_pkg::*;

  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '1;
    else if (clr_i)   crc_q <= '1;
    else if (en_i)    crc_q <= crc_byte(crc_q, data_i);
  end

  assign crc_o = ~crc_q;

  // R5: reseed to all ones means a complemented result of zero
  a_r5_crc_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (crc_o == 32'h0));
endmodule

// File: rtl/rxw_status_gen.sv
module rxw_status_gen #(
  parameter int unsigned CW         = 13,
  parameter int unsigned PAGE_BYTES = 2048,
  parameter int unsigned LONG_LIMIT = 1518
) (
  input  logic [CW-1:0] len_i,
  input  logic          keep_crc_i,
  output logic [15:0]   status_o,
  output logic [15:0]   size_o,
  output logic [CW-1:0] even_o,
  output logic          odd_o,
  output logic          fits_o
);
  localparam int unsigned ODD_BIT  = 12;
  localparam int unsigned LONG_BIT = 11;
  localparam int unsigned BASE_OVH = 6;
  localparam int unsigned CRC_OVH  = 4;

  logic [CW:0] size_full;

  assign odd_o     = len_i[0];
  assign even_o    = {len_i[CW-1:1], 1'b0};
  assign size_full = {1'b0, even_o} + (CW+1)'(BASE_OVH)
                   + (keep_crc_i ? (CW+1)'(CRC_OVH) : '0);
  assign size_o    = 16'(size_full);
  assign fits_o    = size_full <= (CW+1)'(PAGE_BYTES);

  always_comb begin
    status_o = '0;
    status_o[ODD_BIT]  = odd_o;
    status_o[LONG_BIT] = len_i > CW'(LONG_LIMIT);
  end
endmodule

// File: rtl/rx_frame_writer.sv
module rx_frame_writer #(
  parameter int unsigned PAGE_BYTES = 2048,
  parameter int unsigned PAGES      = 4,
  parameter int unsigned MIN_FRAME  = 64,
  parameter int unsigned LONG_LIMIT = 1518,
  localparam int unsigned AW = $clog2(PAGE_BYTES),
  localparam int unsigned PW = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [15:0]   rx_ctrl_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_valid_i,
  input  logic          rx_last_i,
  output logic          rx_ready_o,
  output logic          alloc_req_o,
  input  logic          alloc_gnt_i,
  input  logic [PW-1:0] alloc_page_i,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_page_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          rxq_push_o,
  output logic [PW-1:0] rxq_page_o,
  output logic          release_o,
  output logic [PW-1:0] release_page_o,
  output logic          rx_irq_o
);
  import rxw_pkg::*;

  localparam int unsigned CW       = AW + 2;
  localparam int unsigned HDR_B    = 4;
  localparam int unsigned CRC_B    = 4;
  localparam logic [7:0]  ODD_MARK = 8'h20;

  rxw_state_e    st_q, st_d;
  logic [PW-1:0] page_q;
  logic [CW-1:0] cnt_q, cnt_inc;
  logic          keep_crc_q;
  logic [7:0]    odd_q;
  logic [1:0]    sub_q;

  logic          accept_w, keep_crc_w;
  logic          take, beat, held, in_page;
  logic [CW:0]   dptr, tbase;
  logic [AW-1:0] crc_addr, ctl_addr;
  logic [15:0]   status_w, size_w;
  logic [CW-1:0] even_w;
  logic          odd_w, fits_w;
  logic          crc_clr, crc_en;
  logic [7:0]    crc_din;
  logic [31:0]   crc_w;
  logic          unused_hi;

  rxw_ctrl_decode i_dec (
    .ctrl_i    (rx_ctrl_i),
    .accept_o  (accept_w),
    .keep_crc_o(keep_crc_w)
  );

  rxw_status_gen #(
    .CW(CW), .PAGE_BYTES(PAGE_BYTES), .LONG_LIMIT(LONG_LIMIT)
  ) i_stat (
    .len_i     (cnt_q),
    .keep_crc_i(keep_crc_q),
    .status_o  (status_w),
    .size_o    (size_w),
    .even_o    (even_w),
    .odd_o     (odd_w),
    .fits_o    (fits_w)
  );

  rxw_crc32 i_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (crc_clr),
    .en_i  (crc_en),
    .data_i(crc_din),
    .crc_o (crc_w)
  );

  assign take    = (st_q == S_IDLE) && rx_valid_i && accept_w && alloc_gnt_i;
  assign beat    = take || ((st_q == S_DATA) && rx_valid_i);
  assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + CW'(1);
  // odd final byte of a frame already at minimum length is held for the trailer
  assign held    = rx_last_i && !cnt_q[0] && (cnt_q >= CW'(MIN_FRAME));
  assign dptr    = {1'b0, cnt_q} + (CW+1)'(HDR_B);
  assign in_page = dptr < (CW+1)'(PAGE_BYTES);
  assign tbase   = {1'b0, even_w} + (CW+1)'(HDR_B);
  assign crc_addr = tbase[AW-1:0] + AW'(sub_q);
  assign ctl_addr = tbase[AW-1:0] + (keep_crc_q ? AW'(CRC_B) : '0) + AW'(sub_q);
  assign unused_hi = ^tbase[CW:AW];

  assign crc_clr = (st_q == S_FIN) || ((st_q == S_IDLE) && !take)
                || ((st_q == S_EVAL) && !fits_w);

  assign wr_page_o      = (st_q == S_IDLE) ? alloc_page_i : page_q;
  assign rxq_page_o     = page_q;
  assign release_page_o = page_q;

  always_comb begin
    st_d        = st_q;
    rx_ready_o  = 1'b0;
    alloc_req_o = 1'b0;
    wr_en_o     = 1'b0;
    wr_addr_o   = dptr[AW-1:0];
    wr_data_o   = rx_data_i;
    crc_en      = 1'b0;
    crc_din     = rx_data_i;
    rxq_push_o  = 1'b0;
    release_o   = 1'b0;
    rx_irq_o    = 1'b0;
    unique case (st_q)
      S_IDLE, S_DATA: begin
        rx_ready_o  = 1'b1;
        alloc_req_o = (st_q == S_IDLE) && rx_valid_i && accept_w;
        if (beat) begin
          wr_en_o = !held && in_page;
          crc_en  = 1'b1;
          if (rx_last_i)
            st_d = (cnt_inc < CW'(MIN_FRAME)) ? S_PAD : S_EVAL;
          else
            st_d = S_DATA;
        end else if ((st_q == S_IDLE) && rx_valid_i && !rx_last_i) begin
          st_d = S_DROP;
        end
      end
      S_DROP: begin
        rx_ready_o = 1'b1;
        if (rx_valid_i && rx_last_i) st_d = S_IDLE;
      end
      S_PAD: begin
        wr_en_o   = 1'b1;
        wr_data_o = 8'h00;
        crc_en    = 1'b1;
        crc_din   = 8'h00;
        if (cnt_q == CW'(MIN_FRAME - 1)) st_d = S_EVAL;
      end
      S_EVAL: begin
        if (!fits_w) begin
          release_o = 1'b1;
          st_d      = S_IDLE;
        end else begin
          st_d = keep_crc_q ? S_CRC : S_CTL;
        end
      end
      S_CRC: begin
        wr_en_o   = 1'b1;
        wr_addr_o = crc_addr;
        wr_data_o = crc_w[8*sub_q +: 8];
        if (sub_q == 2'd3) st_d = S_CTL;
      end
      S_CTL: begin
        wr_en_o   = 1'b1;
        wr_addr_o = ctl_addr;
        wr_data_o = (sub_q == 2'd0) ? odd_q : (odd_w ? ODD_MARK : 8'h00);
        if (sub_q == 2'd1) st_d = S_HDR;
      end
      S_HDR: begin
        wr_en_o   = 1'b1;
        wr_addr_o = AW'(sub_q);
        unique case (sub_q)
          2'd0:    wr_data_o = status_w[7:0];
          2'd1:    wr_data_o = status_w[15:8];
          2'd2:    wr_data_o = size_w[7:0];
          default: wr_data_o = size_w[15:8];
        endcase
        if (sub_q == 2'd3) st_d = S_FIN;
      end
      S_FIN: begin
        rxq_push_o = 1'b1;
        rx_irq_o   = 1'b1;
        st_d       = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      page_q     <= '0;
      cnt_q      <= '0;
      keep_crc_q <= 1'b0;
      odd_q      <= '0;
      sub_q      <= '0;
    end else begin
      st_q  <= st_d;
      sub_q <= (st_d != st_q) ? 2'd0 : sub_q + 2'd1;
      if (take) begin
        page_q     <= alloc_page_i;
        keep_crc_q <= keep_crc_w;
      end
      if (beat && rx_last_i) odd_q <= held ? rx_data_i : 8'h00;
      if ((st_q == S_FIN) || ((st_q == S_EVAL) && !fits_w)) cnt_q <= '0;
      else if (beat || (st_q == S_PAD))                     cnt_q <= cnt_inc;
    end
  end

  // R3: consecutive data writes use one page and step the offset by one
  a_r3_page_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> (wr_page_o == $past(wr_page_o)));
  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == S_DATA) && wr_en_o && $past(wr_en_o)
     && (($past(st_q) == S_DATA) || ($past(st_q) == S_IDLE)))
    |-> (wr_addr_o == $past(wr_addr_o) + AW'(1)));
  // R1: a refused frame drains silently
  a_r1_drop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_DROP) |-> (!wr_en_o && !alloc_req_o && !rxq_push_o));
  // R8: header size field is even and covers at least the padded minimum
  a_r8_size_sane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_HDR) |-> (!size_w[0] && (size_w >= 16'(MIN_FRAME + 6))));
  // R10: push follows the last header byte
  a_r10_push_after_hdr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxq_push_o |-> ($past(wr_en_o) && ($past(wr_addr_o) == AW'(HDR_B - 1))));
  // R9: release is a single pulse
  a_r9_release_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |=> !release_o);
endmodule

// File: tb/test_rx_frame_writer.sv
module test_rx_frame_writer;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = CLK_PERIOD / 4;
  localparam int PAGE_BYTES = 2048;

  typedef struct packed {
    logic [1:0]  pg;
    logic [10:0] ad;
    logic [7:0]  dt;
    logic [3:0]  rq;
  } wr_t;
  typedef struct packed {
    logic       push;
    logic [1:0] pg;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rx_ctrl = '0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic        rx_ready, alloc_req, alloc_gnt = 1'b0;
  logic [1:0]  alloc_page = '0;
  logic        wr_en, rxq_push, release_v, rx_irq;
  logic [1:0]  wr_page, rxq_page, release_page;
  logic [10:0] wr_addr;
  logic [7:0]  wr_data;

  int   nchk = 0, nfail = 0;
  bit   done = 1'b0, alloc_seen = 1'b0;
  wr_t  exp_wr[$];
  ev_t  exp_ev[$];
  logic [7:0] fb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_writer i_rx_frame_writer (
    .clk_i(clk), .rst_ni(rst_n), .rx_ctrl_i(rx_ctrl),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_last_i(rx_last),
    .rx_ready_o(rx_ready), .alloc_req_o(alloc_req), .alloc_gnt_i(alloc_gnt),
    .alloc_page_i(alloc_page), .wr_en_o(wr_en), .wr_page_o(wr_page),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .rxq_push_o(rxq_push),
    .rxq_page_o(rxq_page), .release_o(release_v),
    .release_page_o(release_page), .rx_irq_o(rx_irq)
  );

  task automatic check(bit ok, int req, int act, int expv, string what);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: pops scoreboard entries as the design produces them
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (alloc_req) alloc_seen = 1'b1;
      if (wr_en) begin
        if (exp_wr.size() == 0) begin
          check(1'b0, 3, {wr_page, wr_addr, wr_data}, 0, "unexpected write");
        end else begin
          wr_t e;
          e = exp_wr.pop_front();
          check({wr_page, wr_addr, wr_data} == {e.pg, e.ad, e.dt}, int'(e.rq),
                {wr_page, wr_addr, wr_data}, {e.pg, e.ad, e.dt}, "write page/addr/data");
        end
      end
      if (rxq_push || release_v) begin
        if (exp_ev.size() == 0) begin
          check(1'b0, 10, {rxq_push, release_v}, 0, "unexpected push/release");
        end else begin
          ev_t e;
          logic [1:0] pg;
          e  = exp_ev.pop_front();
          pg = rxq_push ? rxq_page : release_page;
          // R10 push, R9 release
          check({rxq_push, release_v, pg} == {e.push, !e.push, e.pg},
                e.push ? 10 : 9, {rxq_push, release_v, pg},
                {e.push, !e.push, e.pg}, "queue event");
          if (rxq_push) check(rx_irq == 1'b1, 10, rx_irq, 1, "irq with push");
        end
      end
      if (rx_irq && !rxq_push) check(1'b0, 10, rx_irq, 0, "irq without push");
    end
  end

  function automatic logic [31:0] ref_crc(int n);
    logic [31:0] c = '1;
    for (int i = 0; i < n; i++) begin
      c ^= {24'h0, fb[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  // driver: builds the expected page image, then streams the frame
  task automatic send(int len, int seed, logic [1:0] pg, bit gnt, logic [15:0] ctrl);
    bit acc, kc, odd;
    int lp, ev, size, base;
    logic [15:0] st;
    logic [31:0] c;
    acc = ctrl[8] && !ctrl[15];   // R1
    kc  = !ctrl[9];               // R5
    fb.delete();
    for (int i = 0; i < len; i++) fb.push_back(8'(seed + i * 7 + (i >> 3)));
    if (acc && gnt) begin
      for (int k = 0; k < len; k++) begin  // R3 data, R6 held byte
        if (!((k == len - 1) && (k % 2 == 0) && (k >= 64)) && (4 + k < PAGE_BYTES))
          exp_wr.push_back('{pg, 11'(4 + k), fb[k], 4'd3});
      end
      lp = len;
      for (int k = len; k < 64; k++) begin  // R4
        exp_wr.push_back('{pg, 11'(4 + k), 8'h00, 4'd4});
        fb.push_back(8'h00);
        lp = 64;
      end
      ev   = lp & ~1;
      odd  = lp[0];
      size = ev + 6 + (kc ? 4 : 0);
      if (size > PAGE_BYTES) begin
        exp_ev.push_back('{1'b0, pg});     // R9
      end else begin
        if (kc) begin                       // R5
          c = ref_crc(lp);
          for (int b = 0; b < 4; b++) exp_wr.push_back('{pg, 11'(4 + ev + b), c[8*b +: 8], 4'd5});
        end
        base = 4 + ev + (kc ? 4 : 0);       // R6
        exp_wr.push_back('{pg, 11'(base), odd ? fb[lp - 1] : 8'h00, 4'd6});
        exp_wr.push_back('{pg, 11'(base + 1), odd ? 8'h20 : 8'h00, 4'd6});
        st = '0;
        st[12] = odd;
        st[11] = (len > 1518);              // R7
        exp_wr.push_back('{pg, 11'd0, st[7:0], 4'd8});   // R8
        exp_wr.push_back('{pg, 11'd1, st[15:8], 4'd7});
        exp_wr.push_back('{pg, 11'd2, 8'(size), 4'd8});
        exp_wr.push_back('{pg, 11'd3, 8'(size >> 8), 4'd8});
        exp_ev.push_back('{1'b1, pg});     // R10
      end
    end
    rx_ctrl    = ctrl;
    alloc_gnt  = gnt;
    alloc_page = pg;
    alloc_seen = 1'b0;
    for (int i = 0; i < len; i++) begin
      check(rx_ready == 1'b1, 3, rx_ready, 1, "ready during frame");
      rx_valid = 1'b1;
      rx_data  = fb[i];
      rx_last  = (i == len - 1);
      @(posedge clk); #Q;
    end
    rx_valid = 1'b0;
    rx_last  = 1'b0;
    while (!rx_ready) begin @(posedge clk); #Q; end
    repeat (2) begin @(posedge clk); #Q; end
    check(exp_wr.size() == 0, 3, exp_wr.size(), 0, "writes left over");
    check(exp_ev.size() == 0, 10, exp_ev.size(), 0, "events left over");
    if (!acc) check(alloc_seen == 1'b0, 1, alloc_seen, 0, "request while disabled");  // R1
    exp_wr.delete();
    exp_ev.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #Q;
    // R11: reset state
    check(rx_ready == 1'b1, 11, rx_ready, 1, "ready in reset");
    check({wr_en, alloc_req, rxq_push, release_v, rx_irq} == 5'b0, 11,
          {wr_en, alloc_req, rxq_push, release_v, rx_irq}, 0, "idle outputs in reset");
    rst_n = 1'b1;
    @(posedge clk); #Q;
    send(60,   8'h11, 2'd1, 1'b1, 16'h0100);  // R4 R5 R8
    send(64,   8'h22, 2'd2, 1'b1, 16'h0300);  // strip CRC
    send(101,  8'h33, 2'd0, 1'b1, 16'h0100);  // R6 odd with CRC
    send(77,   8'h44, 2'd3, 1'b1, 16'h0300);  // R6 odd without CRC
    send(40,   8'h55, 2'd1, 1'b1, 16'h0000);  // R1 disabled
    send(70,   8'h66, 2'd1, 1'b1, 16'h8100);  // R1 soft reset
    send(80,   8'h77, 2'd2, 1'b0, 16'h0100);  // R2 no page
    send(1,    8'h88, 2'd3, 1'b1, 16'h0100);  // R4 single byte
    send(1519, 8'h99, 2'd0, 1'b1, 16'h0100);  // R7 too long
    send(2040, 8'hAA, 2'd1, 1'b1, 16'h0100);  // R9 oversize with CRC
    send(2039, 8'hBB, 2'd2, 1'b1, 16'h0100);  // R9 limit, fits
    send(2043, 8'hCC, 2'd3, 1'b1, 16'h0300);  // R9 limit without CRC
    send(2044, 8'hDD, 2'd0, 1'b1, 16'h0300);  // R9 oversize without CRC
    send(65,   8'hEE, 2'd2, 1'b1, 16'h0100);  // R6 smallest odd
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL R3 watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end
endmodule